// File: doc/BRIEF.md
# Endpoint Buffer Window Allocator

This block keeps the placement table for a shared packet buffer RAM that serves up to eight USB pipes or endpoints. Software writes per-endpoint settings through a small strobe interface: an enable bit, an allocate bit, a buffer size code, a bank code and a free attribute word (direction, transfer type, endpoint number and polling interval packed as the user likes). From these settings the block derives each endpoint's window length and, whenever the allocate bit of an endpoint changes, its start address in the RAM.

Placement follows a deliberately local slide rule. Allocating or freeing endpoint k moves endpoint k itself and at most the one window directly above it. All higher windows keep their stored start addresses, even when this makes windows overlap. Because of this, the block also flags every allocated window that overlaps another allocated window or runs past the end of the RAM. A separate configuration-OK flag reports only whether the size and bank settings are legal. A combinational lookup port returns the base address, length, enable, allocate and attribute word of any endpoint.

Overlap flags are recomputed by a two-state controller. `ST_IDLE` moves to `ST_SETTLE` on any accepted write (transition T_ARM). `ST_SETTLE` loads the overlap flags. It stays in `ST_SETTLE` if another write arrives (T_REARM) and otherwise returns to `ST_IDLE` (T_DONE). The block does not move data, run USB transactions or contain the RAM.

Top module: `ep_window_alloc`

## Requirements
- R1: A write to the enable field changes only that endpoint's enable bit. Its allocate bit, size code, bank code, attribute word and start address stay unchanged.
- R2: Disabling an endpoint releases no buffer space. The base and length of the endpoint and of every other endpoint stay as they were.
- R3: Clearing the allocate bit of endpoint k (when it was set) moves endpoint k+1, if allocated, to endpoint k's stored start address. This happens at the same clock edge as the write.
- R4: Any allocate write on endpoint k leaves the start addresses of endpoints k+2 and above unchanged.
- R5: Setting the allocate bit of endpoint k (when it was clear) places k at the end of the highest-numbered allocated endpoint below k, or at 0 if there is none. Endpoint k+1, if allocated, moves to start just after k's new window. Both updates take effect at the write edge. Writing the allocate bit with the value it already holds moves nothing.
- R6: Endpoint 0, when allocated, always starts at address 0.
- R7: Every write of 1 to the allocate field reloads that endpoint's configuration-OK flag. The flag is 1 only when all three of these hold: the size code is no more than 3 for endpoint 0 (7 for others); the bank code is no more than 0 for endpoint 0 (2 for others); and the length is at most 2048 bytes. Overlaps are ignored. No other write changes the flag.
- R8: Length is (8 << size code) × (bank code + 1) bytes. The size code is 3 bits and the bank code is 2 bits, meaning banks − 1. The lookup port returns base, length, enable, allocate and attribute of `lk_ep` combinationally.
- R9: Conflict bit i is 1 when endpoint i is allocated and either its window overlaps another allocated window or its end exceeds 2048. The flags change only on the second rising edge after an accepted write.
- R10: On a contiguous layout, clearing and then setting the allocate bit of one endpoint with unchanged settings restores every window's start address.
- R11: After reset, all enable, allocate, configuration-OK and conflict bits are 0. All codes, attribute words and bases are 0.
- R12: Field select codes are 0 enable (data bit 0), 1 allocate (bit 0), 2 size (bits 2:0), 3 bank code (bits 1:0) and 4 attribute (bits 15:0). A write with field code 5 to 7, or with an endpoint index out of range, changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_valid | input | 1 | Write strobe |
| wr_ep | input | 3 | Endpoint index of the write |
| wr_field | input | 3 | Field select code |
| wr_data | input | 16 | Write data |
| lk_ep | input | 3 | Endpoint index for lookup |
| lk_base | output | 16 | Start address of the looked-up window |
| lk_len | output | 13 | Length in bytes of the looked-up window |
| lk_enable | output | 1 | Enable bit of the looked-up endpoint |
| lk_alloc | output | 1 | Allocate bit of the looked-up endpoint |
| lk_attr | output | 16 | Attribute word of the looked-up endpoint |
| cfg_ok | output | 8 | Configuration-OK flag per endpoint |
| conflict | output | 8 | Overlap or overrun flag per endpoint |

## Verification
Table fields, bases, lengths and the configuration-OK flags are due at the rising edge that takes the write. The bench therefore reads them through the lookup port on the falling edge after that edge. The conflict flags are due one rising edge later. On every write the bench first confirms, at the first falling edge, that the flags still hold their previous value. It then compares them with the model at the next falling edge, so an early or a late update is caught.

// File: rtl/epw_pkg.sv
`timescale 1ns/1ps
package epw_pkg;

    typedef enum logic [2:0] {
        FLD_ENABLE = 3'd0,
        FLD_ALLOC  = 3'd1,
        FLD_SIZE   = 3'd2,
        FLD_BANKS  = 3'd3,
        FLD_ATTR   = 3'd4
    } epw_field_e;

    typedef enum logic {
        ST_IDLE   = 1'b0,
        ST_SETTLE = 1'b1
    } epw_state_e;

    function automatic int unsigned win_bytes(logic [2:0] sz, logic [1:0] bk);
        return (32'd8 << sz) * (32'(bk) + 32'd1);
    endfunction

endpackage

// File: rtl/epw_cfg_bank.sv
`timescale 1ns/1ps
module epw_cfg_bank #(
    parameter int NUM_EP        = 8,
    parameter int ATTR_W        = 16,
    parameter int LEN_W         = 13,
    parameter int RAM_BYTES     = 2048,
    parameter int EP0_MAX_SIZE  = 3,
    parameter int EP0_MAX_BANK  = 0,
    parameter int MAX_SIZE      = 7,
    parameter int MAX_BANK      = 2,
    localparam int EP_W         = (NUM_EP > 1) ? $clog2(NUM_EP) : 1
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           wr_ok,
    input  logic [EP_W-1:0]                wr_ep,
    input  logic [2:0]                     wr_field,
    input  logic [ATTR_W-1:0]              wr_data,
    output logic [NUM_EP-1:0]              en_q,
    output logic [NUM_EP-1:0]              alloc_q,
    output logic [NUM_EP-1:0][2:0]         size_q,
    output logic [NUM_EP-1:0][1:0]         bank_q,
    output logic [NUM_EP-1:0][ATTR_W-1:0]  attr_q,
    output logic [NUM_EP-1:0][LEN_W-1:0]   len,
    output logic [NUM_EP-1:0]              cfg_ok_q
);
    import epw_pkg::*;

    logic [NUM_EP-1:0] fits;

    for (genvar i = 0; i < NUM_EP; i++) begin : g_ep
        localparam int SZ_LIM = (i == 0) ? EP0_MAX_SIZE : MAX_SIZE;
        localparam int BK_LIM = (i == 0) ? EP0_MAX_BANK : MAX_BANK;
        int unsigned bytes;
        always_comb begin
            bytes   = win_bytes(size_q[i], bank_q[i]);
            len[i]  = LEN_W'(bytes);
            fits[i] = (int'(size_q[i]) <= SZ_LIM) && (int'(bank_q[i]) <= BK_LIM)
                      && (bytes <= RAM_BYTES);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q     <= '0;
            alloc_q  <= '0;
            size_q   <= '0;
            bank_q   <= '0;
            attr_q   <= '0;
            cfg_ok_q <= '0;
        end else if (wr_ok) begin
            case (wr_field)
                FLD_ENABLE: en_q[wr_ep] <= wr_data[0];
                FLD_ALLOC: begin
                    alloc_q[wr_ep] <= wr_data[0];
                    if (wr_data[0]) cfg_ok_q[wr_ep] <= fits[wr_ep];
                end
                FLD_SIZE:  size_q[wr_ep] <= wr_data[2:0];
                FLD_BANKS: bank_q[wr_ep] <= wr_data[1:0];
                FLD_ATTR:  attr_q[wr_ep] <= wr_data;
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/epw_base_table.sv
`timescale 1ns/1ps
module epw_base_table #(
    parameter int NUM_EP = 8,
    parameter int LEN_W  = 13,
    parameter int AW     = 16,
    localparam int EP_W  = (NUM_EP > 1) ? $clog2(NUM_EP) : 1
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          alloc_wr,
    input  logic [EP_W-1:0]               wr_ep,
    input  logic                          set_bit,
    input  logic [NUM_EP-1:0]             alloc_q,
    input  logic [NUM_EP-1:0][LEN_W-1:0]  len,
    output logic [NUM_EP-1:0][AW-1:0]     base_q
);
    logic [AW-1:0]              prev_end;
    logic [EP_W-1:0]            up_ep;
    logic                       has_up;
    logic [NUM_EP-1:0][AW-1:0]  base_d;

    always_comb begin
        prev_end = '0;
        for (int j = 0; j < NUM_EP; j++) begin
            if (j < int'(wr_ep) && alloc_q[j]) prev_end = base_q[j] + AW'(len[j]);
        end
        up_ep  = wr_ep + 1'b1;
        has_up = (int'(wr_ep) < NUM_EP - 1) && alloc_q[up_ep];
        base_d = base_q;
        if (alloc_wr && (alloc_q[wr_ep] != set_bit)) begin
            if (set_bit) begin
                base_d[wr_ep] = prev_end;
                if (has_up) base_d[up_ep] = prev_end + AW'(len[wr_ep]);
            end else if (has_up) begin
                base_d[up_ep] = base_q[wr_ep];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) base_q <= '0;
        else        base_q <= base_d;
    end

endmodule

// File: rtl/epw_overlap_scan.sv
`timescale 1ns/1ps
module epw_overlap_scan #(
    parameter int NUM_EP    = 8,
    parameter int LEN_W     = 13,
    parameter int AW        = 16,
    parameter int RAM_BYTES = 2048
) (
    input  logic [NUM_EP-1:0]             alloc_q,
    input  logic [NUM_EP-1:0][AW-1:0]     base_q,
    input  logic [NUM_EP-1:0][LEN_W-1:0]  len,
    output logic [NUM_EP-1:0]             hit
);
    logic [NUM_EP-1:0][AW:0] stop;

    for (genvar i = 0; i < NUM_EP; i++) begin : g_end
        assign stop[i] = {1'b0, base_q[i]} + (AW+1)'(len[i]);
    end

    for (genvar i = 0; i < NUM_EP; i++) begin : g_hit
        always_comb begin
            hit[i] = alloc_q[i] && (stop[i] > (AW+1)'(RAM_BYTES));
            for (int j = 0; j < NUM_EP; j++) begin
                if (j != i && alloc_q[i] && alloc_q[j]
                    && ({1'b0, base_q[i]} < stop[j]) && ({1'b0, base_q[j]} < stop[i]))
                    hit[i] = 1'b1;
            end
        end
    end

endmodule

// File: rtl/ep_window_alloc.sv
`timescale 1ns/1ps
module ep_window_alloc #(
    parameter int NUM_EP       = 8,
    parameter int RAM_BYTES    = 2048,
    parameter int ATTR_W       = 16,
    parameter int EP0_MAX_SIZE = 3,
    parameter int EP0_MAX_BANK = 0,
    parameter int MAX_SIZE     = 7,
    parameter int MAX_BANK     = 2,
    localparam int EP_W        = (NUM_EP > 1) ? $clog2(NUM_EP) : 1,
    localparam int LEN_W       = $clog2((8 << 7) * 4) + 1,
    localparam int AW          = LEN_W + EP_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_valid,
    input  logic [EP_W-1:0]    wr_ep,
    input  logic [2:0]         wr_field,
    input  logic [ATTR_W-1:0]  wr_data,
    input  logic [EP_W-1:0]    lk_ep,
    output logic [AW-1:0]      lk_base,
    output logic [LEN_W-1:0]   lk_len,
    output logic               lk_enable,
    output logic               lk_alloc,
    output logic [ATTR_W-1:0]  lk_attr,
    output logic [NUM_EP-1:0]  cfg_ok,
    output logic [NUM_EP-1:0]  conflict
);
    import epw_pkg::*;

    logic                           wr_ok;
    logic [NUM_EP-1:0]              en_q;
    logic [NUM_EP-1:0]              alloc_q;
    logic [NUM_EP-1:0][2:0]         size_q;
    logic [NUM_EP-1:0][1:0]         bank_q;
    logic [NUM_EP-1:0][ATTR_W-1:0]  attr_q;
    logic [NUM_EP-1:0][LEN_W-1:0]   len;
    logic [NUM_EP-1:0][AW-1:0]      base_q;
    logic [NUM_EP-1:0]              hit;
    epw_state_e                     state_q, state_d;
    logic                           load_conf;

    assign wr_ok = wr_valid && (int'(wr_ep) < NUM_EP);

    epw_cfg_bank #(
        .NUM_EP(NUM_EP), .ATTR_W(ATTR_W), .LEN_W(LEN_W), .RAM_BYTES(RAM_BYTES),
        .EP0_MAX_SIZE(EP0_MAX_SIZE), .EP0_MAX_BANK(EP0_MAX_BANK),
        .MAX_SIZE(MAX_SIZE), .MAX_BANK(MAX_BANK)
    ) u_cfg (
        .clk(clk), .rst_n(rst_n), .wr_ok(wr_ok), .wr_ep(wr_ep),
        .wr_field(wr_field), .wr_data(wr_data),
        .en_q(en_q), .alloc_q(alloc_q), .size_q(size_q), .bank_q(bank_q),
        .attr_q(attr_q), .len(len), .cfg_ok_q(cfg_ok)
    );

    epw_base_table #(.NUM_EP(NUM_EP), .LEN_W(LEN_W), .AW(AW)) u_base (
        .clk(clk), .rst_n(rst_n),
        .alloc_wr(wr_ok && (wr_field == FLD_ALLOC)),
        .wr_ep(wr_ep), .set_bit(wr_data[0]),
        .alloc_q(alloc_q), .len(len), .base_q(base_q)
    );

    epw_overlap_scan #(.NUM_EP(NUM_EP), .LEN_W(LEN_W), .AW(AW), .RAM_BYTES(RAM_BYTES)) u_scan (
        .alloc_q(alloc_q), .base_q(base_q), .len(len), .hit(hit)
    );

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Next state and outputs
    always_comb begin
        state_d   = state_q;
        load_conf = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (wr_ok) state_d = ST_SETTLE;            // T_ARM
            end
            ST_SETTLE: begin
                load_conf = 1'b1;
                state_d   = wr_ok ? ST_SETTLE : ST_IDLE;   // T_REARM / T_DONE
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n)         conflict <= '0;
        else if (load_conf) conflict <= hit;
    end

    always_comb begin
        lk_base   = '0;
        lk_len    = '0;
        lk_enable = 1'b0;
        lk_alloc  = 1'b0;
        lk_attr   = '0;
        if (int'(lk_ep) < NUM_EP) begin
            lk_base   = base_q[lk_ep];
            lk_len    = len[lk_ep];
            lk_enable = en_q[lk_ep];
            lk_alloc  = alloc_q[lk_ep];
            lk_attr   = attr_q[lk_ep];
        end
    end

endmodule

// File: rtl/epw_checker.sv
`timescale 1ns/1ps
module epw_checker #(
    parameter int NUM_EP = 8,
    parameter int ATTR_W = 16,
    parameter int LEN_W  = 13,
    parameter int AW     = 16,
    localparam int EP_W  = (NUM_EP > 1) ? $clog2(NUM_EP) : 1
) (
    input logic                           clk,
    input logic                           rst_n,
    input logic                           wr_valid,
    input logic [EP_W-1:0]                wr_ep,
    input logic [2:0]                     wr_field,
    input logic [ATTR_W-1:0]              wr_data,
    input logic [NUM_EP-1:0]              alloc_q,
    input logic [NUM_EP-1:0][2:0]         size_q,
    input logic [NUM_EP-1:0][1:0]         bank_q,
    input logic [NUM_EP-1:0][ATTR_W-1:0]  attr_q,
    input logic [NUM_EP-1:0][AW-1:0]      base_q,
    input logic [NUM_EP-1:0]              cfg_ok,
    input logic [NUM_EP-1:0]              conflict,
    input epw_pkg::epw_state_e            state_q
);
    import epw_pkg::*;

    logic wr_in_range;
    assign wr_in_range = wr_valid && (int'(wr_ep) < NUM_EP);

    assert_enable_keeps_cfg_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && wr_field == FLD_ENABLE) |=>
            ($stable(alloc_q) && $stable(size_q) && $stable(bank_q)
             && $stable(attr_q) && $stable(base_q)));

    assert_ep0_at_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
        alloc_q[0] |-> (base_q[0] == '0));

    for (genvar i = 2; i < NUM_EP; i++) begin : g_far
        assert_far_window_still_R4: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_valid && wr_field == FLD_ALLOC && (int'(wr_ep) + 1 < i)) |=> $stable(base_q[i]));
    end

    assert_cfgok_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_in_range && wr_field == FLD_ALLOC && wr_data[0]) |=> $stable(cfg_ok));

    assert_conflict_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE) |=> $stable(conflict));

    assert_settle_after_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
        wr_in_range |=> (state_q == ST_SETTLE));

endmodule

bind ep_window_alloc epw_checker #(
    .NUM_EP(NUM_EP), .ATTR_W(ATTR_W), .LEN_W(LEN_W), .AW(AW)
) u_chk (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_ep(wr_ep),
    .wr_field(wr_field), .wr_data(wr_data), .alloc_q(alloc_q), .size_q(size_q),
    .bank_q(bank_q), .attr_q(attr_q), .base_q(base_q), .cfg_ok(cfg_ok),
    .conflict(conflict), .state_q(state_q)
);

// File: tb/ep_window_alloc_test.sv
`timescale 1ns/1ps
module ep_window_alloc_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_valid = 1'b0;
    logic [2:0]  wr_ep = '0;
    logic [2:0]  wr_field = '0;
    logic [15:0] wr_data = '0;
    logic [2:0]  lk_ep = '0;
    logic [15:0] lk_base;
    logic [12:0] lk_len;
    logic        lk_enable, lk_alloc;
    logic [15:0] lk_attr;
    logic [7:0]  cfg_ok, conflict;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    int m_en[8], m_al[8], m_sz[8], m_bk[8], m_at[8], m_base[8], m_ok[8], m_cf[8];

    ep_window_alloc uut (
        .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_ep(wr_ep),
        .wr_field(wr_field), .wr_data(wr_data), .lk_ep(lk_ep),
        .lk_base(lk_base), .lk_len(lk_len), .lk_enable(lk_enable),
        .lk_alloc(lk_alloc), .lk_attr(lk_attr), .cfg_ok(cfg_ok), .conflict(conflict)
    );

    always #10 clk = ~clk;

    function automatic int mlen(int i);
        return (8 << m_sz[i]) * (m_bk[i] + 1);
    endfunction

    function automatic int mfits(int i);
        int smax = (i == 0) ? 3 : 7;
        int bmax = (i == 0) ? 0 : 2;
        return (m_sz[i] <= smax && m_bk[i] <= bmax && mlen(i) <= 2048) ? 1 : 0;
    endfunction

    task automatic model_write(int ep, int f, int d);
        int b, pe;
        case (f)
            0: m_en[ep] = d & 1;
            1: begin
                b = d & 1;
                if (b == 1) m_ok[ep] = mfits(ep);
                if (m_al[ep] != b) begin
                    if (b == 1) begin
                        pe = 0;
                        for (int j = 0; j < ep; j++) if (m_al[j] == 1) pe = m_base[j] + mlen(j);
                        m_base[ep] = pe;
                        if (ep < 7 && m_al[ep+1] == 1) m_base[ep+1] = pe + mlen(ep);
                    end else if (ep < 7 && m_al[ep+1] == 1) begin
                        m_base[ep+1] = m_base[ep];
                    end
                    m_al[ep] = b;
                end
            end
            2: m_sz[ep] = d & 7;
            3: m_bk[ep] = d & 3;
            4: m_at[ep] = d & 16'hffff;
            default: ;
        endcase
    endtask

    task automatic model_conflict();
        for (int i = 0; i < 8; i++) begin
            m_cf[i] = 0;
            if (m_al[i] == 1) begin
                if (m_base[i] + mlen(i) > 2048) m_cf[i] = 1;
                for (int j = 0; j < 8; j++)
                    if (j != i && m_al[j] == 1 && m_base[i] < m_base[j] + mlen(j)
                        && m_base[j] < m_base[i] + mlen(i)) m_cf[i] = 1;
            end
        end
    endtask

    task automatic check(string req, int act, int exp, string what);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic int cfpack();
        int v = 0;
        for (int i = 0; i < 8; i++) v |= (m_cf[i] << i);
        return v;
    endfunction

    function automatic int okpack();
        int v = 0;
        for (int i = 0; i < 8; i++) v |= (m_ok[i] << i);
        return v;
    endfunction

    task automatic look(int ep);
        lk_ep = 3'(ep);
        #1;
    endtask

    task automatic check_all();
        for (int e = 0; e < 8; e++) begin
            look(e);
            check("R5", int'(lk_base), m_base[e], "base");
            check("R8", int'(lk_len), mlen(e), "length");
            check("R12", int'(lk_alloc), m_al[e], "alloc");
            check("R1", int'(lk_enable), m_en[e], "enable");
            check("R12", int'(lk_attr), m_at[e], "attr");
        end
        check("R7", int'(cfg_ok), okpack(), "cfg_ok");
        check("R9", int'(conflict), cfpack(), "conflict");
    endtask

    task automatic do_write(int ep, int f, int d);
        @(negedge clk);
        wr_valid = 1'b1; wr_ep = 3'(ep); wr_field = 3'(f); wr_data = 16'(d);
        @(negedge clk);
        wr_valid = 1'b0;
        model_write(ep, f, d);
        check("R9", int'(conflict), cfpack(), "conflict before settle");
        @(negedge clk);
        model_conflict();
        check_all();
    endtask

    initial begin
        #(20ns * 150000);
        if (!done) begin
            n_bad++; n_chk++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4711));
        for (int i = 0; i < 8; i++) begin
            m_en[i] = 0; m_al[i] = 0; m_sz[i] = 0; m_bk[i] = 0;
            m_at[i] = 0; m_base[i] = 0; m_ok[i] = 0; m_cf[i] = 0;
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R11", int'(cfg_ok), 0, "cfg_ok after reset");
        check("R11", int'(conflict), 0, "conflict after reset");
        look(5);
        check("R11", int'(lk_base) + int'(lk_alloc) + int'(lk_enable) + int'(lk_attr), 0, "table after reset");

        // Build layout: lengths 64,128,128,128,64,64
        do_write(0, 2, 3); do_write(1, 2, 4); do_write(2, 2, 3); do_write(2, 3, 1);
        do_write(3, 2, 4); do_write(4, 2, 3); do_write(5, 2, 3);
        for (int e = 0; e < 6; e++) begin do_write(e, 0, 1); do_write(e, 1, 1); end
        look(5); check("R5", int'(lk_base), 512, "ep5 base after build");
        look(0); check("R6", int'(lk_base), 0, "ep0 base");

        // Clear and set ep2 with same settings
        do_write(2, 1, 0);
        look(3); check("R3", int'(lk_base), 192, "ep3 slid down");
        do_write(2, 1, 1);
        look(3); check("R10", int'(lk_base), 320, "ep3 restored");
        look(4); check("R10", int'(lk_base), 448, "ep4 restored");

        // Disable ep3
        do_write(3, 0, 0);
        look(3); check("R1", int'(lk_alloc), 1, "alloc kept on disable");
        check("R2", int'(lk_base), 320, "ep3 base kept on disable");
        look(4); check("R2", int'(lk_base), 448, "ep4 base kept on disable");

        // Free ep3
        do_write(3, 1, 0);
        look(4); check("R3", int'(lk_base), 320, "ep4 slid down");
        look(5); check("R4", int'(lk_base), 512, "ep5 unmoved");

        // Larger ep3, reallocate
        do_write(3, 2, 6); do_write(3, 1, 1);
        look(3); check("R5", int'(lk_base), 320, "ep3 new base");
        look(4); check("R5", int'(lk_base), 832, "ep4 slid up");
        check("R9", int'(conflict), 8'h28, "ep3/ep5 overlap");
        check("R7", int'(cfg_ok[3]), 1, "cfg_ok ignores overlap");

        // Ignored field code
        do_write(1, 5, 0);
        look(1); check("R12", int'(lk_alloc), 1, "field 5 ignored");

        // Illegal ep0 bank setting
        do_write(0, 3, 1); do_write(0, 1, 1);
        check("R7", int'(cfg_ok[0]), 0, "ep0 two banks rejected");
        look(0); check("R6", int'(lk_base), 0, "ep0 base stays zero");

        // Random phase
        for (int n = 0; n < 400; n++) begin
            int ep = int'($urandom % 8);
            int f  = int'($urandom % 6);
            int d;
            case (f)
                2: d = int'($urandom % 6);
                3: d = int'($urandom % 4);
                4: d = int'($urandom % 65536);
                default: d = int'($urandom % 2);
            endcase
            do_write(ep, f, d);
        end

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

endmodule